// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects interrupt events for a small 8-bit processor core and turns them into one vectored request. Each source has its own pending latch. A pulse on that source's event line sets the latch, and it stays set until the core services that source or the block is reset. A per-source enable mask, held in byte-wide registers that the core writes and reads, decides which pending sources count as active. Among the active sources, the lowest-numbered one always wins.

A global enable bit is controlled by strobes from the core: disable-interrupts, enable-interrupts, return-from-interrupt and acknowledge. When the core reports that an instruction has completed, the global enable is set and some source is active, the block raises a request. The request carries the winner's vector address, and both stay frozen until the core acknowledges. The acknowledge drops the global enable and clears the winner's pending latch, so the core can issue its automatic call. A status register reports an interrupt-sense bit and the global enable. The sense bit shows an active source even while interrupts are globally off, so firmware can poll for it.

Top module: `vpic_top`

## Requirements
- R1: A one-cycle pulse on `src_evt[n]` sets pending latch n. The latch stays set, whatever the other inputs do, until source n is acknowledged or `rst` is applied.
- R2: A pending source counts as active only when its enable bit is set. Enable bits for sources 0..7 are bits 0..7 of the register at address 0x20. Enable bits for sources 8..10 are bits 0..2 of the register at address 0x21, and the unused upper bits of 0x21 always read 0.
- R3: `irq_req` rises on the clock edge at which `instr_done` is 1, the global enable is 1 and at least one source is active. It never rises otherwise. Once high, it and `irq_vec` hold their values until `irq_ack` is sampled high.
- R4: When several sources are active, the lowest-numbered one wins. The vector for source n is 2*(n+1), and address 0 is left as the reset entry.
- R5: An `irq_ack` taken while `irq_req` is high clears the global enable and the winner's pending latch, and `irq_req` falls on that same edge. An `irq_ack` taken while `irq_req` is low has no effect.
- R6: If `src_evt[n]` is high on the same edge at which source n is acknowledged, the latch stays set and the event is not lost.
- R7: `cpu_di` clears the global enable, and `cpu_ei` or `cpu_reti` sets it. If `cpu_di` and `cpu_ei` arrive on the same edge, `cpu_di` wins. An acknowledge overrides all of them.
- R8: The status register is at address 0xFF. Bit 7 is the sense bit, bit 2 is the global enable and the other bits are 0. A read returns data on `reg_rdata` one cycle after `reg_rd`, and a read of an unmapped address returns 0.
- R9: `irq_sense` is 1 whenever some source is pending and enabled, including while the global enable is 0.
- R10: `rst` (synchronous, active high) clears all pending latches, the enable registers, the global enable and the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_evt | input | N | One-cycle event pulse per source |
| instr_done | input | 1 | Core has completed the current instruction |
| irq_ack | input | 1 | Core takes the presented request |
| cpu_di | input | 1 | Disable-interrupts strobe |
| cpu_ei | input | 1 | Enable-interrupts strobe |
| cpu_reti | input | 1 | Return-from-interrupt strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Interrupt request to the core |
| irq_vec | output | VEC_W | Vector address of the presented request |
| irq_sense | output | 1 | Some source is pending and enabled |
| gie_o | output | 1 | Global enable state |

## Verification
The hardest case to reach is the collision of a fresh event with the acknowledge that clears the same source. The stimulus isolates one enabled source, raises its request, then pulses that source's event line on the exact acknowledge edge. It then shows that the source can be requested again. A second hard case is a higher-priority source that arrives while a request is already being held. The bench injects it between the raise and the acknowledge and checks that the vector does not move.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam logic [7:0] ENA_BASE   = 8'h20;
  localparam logic [7:0] STAT_ADDR  = 8'hFF;
  localparam int         STAT_SENSE = 7;
  localparam int         STAT_GIE   = 2;

  typedef struct packed {
    logic ack;
    logic di;
    logic ei;
    logic reti;
  } gie_ctl_t;
endpackage

// File: rtl/vpic_pend_bank.sv
module vpic_pend_bank #(
  parameter int N     = 11,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     evt,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  output logic [N-1:0]     pend
);
  for (genvar g = 0; g < N; g++) begin : g_latch
    logic hit;
    assign hit = clr_en && (clr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst) pend[g] <= 1'b0;
      else     pend[g] <= evt[g] | (pend[g] & ~hit);
    end
  end
endmodule

// File: rtl/vpic_prio_enc.sv
module vpic_prio_enc #(
  parameter int N     = 11,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        any = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vpic_gie.sv
module vpic_gie
  import vpic_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  gie_ctl_t ctl,
  output logic     gie
);
  always_ff @(posedge clk) begin
    if (rst)                     gie <= 1'b0;
    else if (ctl.ack)            gie <= 1'b0;
    else if (ctl.di)             gie <= 1'b0;
    else if (ctl.ei || ctl.reti) gie <= 1'b1;
  end
endmodule

// File: rtl/vpic_regs.sv
module vpic_regs
  import vpic_pkg::*;
#(
  parameter int N = 11
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [7:0]   reg_addr,
  input  logic [7:0]   reg_wdata,
  input  logic         sense,
  input  logic         gie,
  output logic [N-1:0] ena,
  output logic [7:0]   reg_rdata
);
  localparam int NREG = (N + 7) / 8;
  localparam int PADW = NREG * 8;
  localparam logic [PADW-1:0] VALID = ~({PADW{1'b1}} << N);

  logic [PADW-1:0] ena_q;
  logic [7:0]      rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ena_q <= '0;
    end else if (reg_wr) begin
      for (int k = 0; k < NREG; k++) begin
        if (reg_addr == ENA_BASE + 8'(k))
          ena_q[k*8 +: 8] <= reg_wdata & VALID[k*8 +: 8];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == STAT_ADDR) begin
      rd_mux[STAT_SENSE] = sense;
      rd_mux[STAT_GIE]   = gie;
    end
    for (int k = 0; k < NREG; k++) begin
      if (reg_addr == ENA_BASE + 8'(k)) rd_mux = ena_q[k*8 +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign ena = ena_q[N-1:0];
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int N     = 11,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     src_evt,
  input  logic             instr_done,
  input  logic             irq_ack,
  input  logic             cpu_di,
  input  logic             cpu_ei,
  input  logic             cpu_reti,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [7:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec,
  output logic             irq_sense,
  output logic             gie_o
);
  localparam int IDX_W = $clog2(N);

  logic [N-1:0]     pend, ena, act;
  logic             any;
  logic [IDX_W-1:0] win, win_q;
  logic             req_q, ack_eff, gie;
  logic [VEC_W-1:0] vec_q;
  gie_ctl_t         ctl;

  assign ack_eff  = irq_ack & req_q;
  assign act      = pend & ena;
  assign ctl.ack  = ack_eff;
  assign ctl.di   = cpu_di;
  assign ctl.ei   = cpu_ei;
  assign ctl.reti = cpu_reti;

  vpic_pend_bank #(.N(N), .IDX_W(IDX_W)) u_pend (
    .clk(clk), .rst(rst), .evt(src_evt),
    .clr_en(ack_eff), .clr_idx(win_q), .pend(pend)
  );

  vpic_prio_enc #(.N(N), .IDX_W(IDX_W)) u_enc (
    .act(act), .any(any), .idx(win)
  );

  vpic_gie u_gie (.clk(clk), .rst(rst), .ctl(ctl), .gie(gie));

  vpic_regs #(.N(N)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .sense(irq_sense), .gie(gie), .ena(ena), .reg_rdata(reg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q <= 1'b0;
      vec_q <= '0;
      win_q <= '0;
    end else if (req_q) begin
      if (irq_ack) req_q <= 1'b0;
    end else if (instr_done && gie && any) begin
      req_q <= 1'b1;
      win_q <= win;
      vec_q <= VEC_W'((32'(win) + 1) * 2);
    end
  end

  assign irq_sense = |act;
  assign irq_req   = req_q;
  assign irq_vec   = vec_q;
  assign gie_o     = gie;
endmodule

// File: rtl/vpic_checker.sv
module vpic_checker #(
  parameter int N     = 11,
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             instr_done,
  input logic             irq_ack,
  input logic             cpu_di,
  input logic             cpu_ei,
  input logic             cpu_reti,
  input logic             irq_req,
  input logic [VEC_W-1:0] irq_vec,
  input logic             irq_sense,
  input logic             gie_o
);
  assert_req_boundary_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(instr_done) && $past(gie_o));

  assert_req_hold_R3: assert property (@(posedge clk) disable iff (rst)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  assert_vec_form_R4: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_vec[0] == 1'b0) && (irq_vec != '0) && (irq_vec <= VEC_W'(2 * N)));

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (rst)
    irq_req && irq_ack |=> !irq_req && !gie_o);

  assert_di_wins_R7: assert property (@(posedge clk) disable iff (rst)
    cpu_di |=> !gie_o);

  assert_ei_sets_R7: assert property (@(posedge clk) disable iff (rst)
    (cpu_ei || cpu_reti) && !cpu_di && !(irq_req && irq_ack) |=> gie_o);

  assert_req_from_sense_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_req) |-> $past(irq_sense));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> !irq_req && !gie_o && !irq_sense);
endmodule

bind vpic_top vpic_checker #(.N(N), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .instr_done(instr_done), .irq_ack(irq_ack),
  .cpu_di(cpu_di), .cpu_ei(cpu_ei), .cpu_reti(cpu_reti),
  .irq_req(irq_req), .irq_vec(irq_vec), .irq_sense(irq_sense), .gie_o(gie_o)
);

// File: tb/test_vpic_top.sv
module test_vpic_top;
  localparam int N     = 11;
  localparam int VEC_W = 8;

  typedef struct packed {
    logic [10:0] evt;
    logic [10:0] ena;
    logic [7:0]  vec;
    logic        req;
  } tv_t;

  localparam tv_t TAB [8] = '{
    '{11'h001, 11'h7FF, 8'd2,  1'b1},
    '{11'h7FF, 11'h7FF, 8'd2,  1'b1},
    '{11'h400, 11'h7FF, 8'd22, 1'b1},
    '{11'h0C0, 11'h7FF, 8'd14, 1'b1},
    '{11'h0C0, 11'h080, 8'd16, 1'b1},
    '{11'h300, 11'h200, 8'd20, 1'b1},
    '{11'h0FF, 11'h000, 8'd0,  1'b0},
    '{11'h106, 11'h104, 8'd6,  1'b1}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] src_evt = '0;
  logic instr_done = 1'b0, irq_ack = 1'b0;
  logic cpu_di = 1'b0, cpu_ei = 1'b0, cpu_reti = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_req, irq_sense, gie_o;
  logic [VEC_W-1:0] irq_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vpic_top #(.N(N), .VEC_W(VEC_W)) i_vpic_top (
    .clk(clk), .rst(rst), .src_evt(src_evt), .instr_done(instr_done),
    .irq_ack(irq_ack), .cpu_di(cpu_di), .cpu_ei(cpu_ei), .cpu_reti(cpu_reti),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vec(irq_vec), .irq_sense(irq_sense), .gie_o(gie_o)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; cyc(); cyc(); rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; cyc(); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    reg_rd = 1'b1; reg_addr = a; cyc(); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic set_ena(input logic [10:0] m);
    wr(8'h20, m[7:0]);
    wr(8'h21, {5'b0, m[10:8]});
  endtask

  task automatic pulse_evt(input logic [10:0] e);
    src_evt = e; cyc(); src_evt = '0;
  endtask

  task automatic pulse_ei();
    cpu_ei = 1'b1; cyc(); cpu_ei = 1'b0;
  endtask

  task automatic pulse_done();
    instr_done = 1'b1; cyc(); instr_done = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; cyc(); irq_ack = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    cyc(); cyc(); rst = 1'b0;

    // R10: reset state
    chk("R10 req after reset", irq_req, 0);
    chk("R10 gie after reset", gie_o, 0);
    chk("R10 sense after reset", irq_sense, 0);
    rd(8'h20, d); chk("R10 ena reg 0x20", d, 0);
    rd(8'hFF, d); chk("R8 status after reset", d, 0);

    // Table walk: R4 priority and vectors, R2 masking, R5 ack effect
    for (int t = 0; t < 8; t++) begin
      logic [10:0] rest;
      do_reset();
      set_ena(TAB[t].ena);
      pulse_evt(TAB[t].evt);
      pulse_ei();
      pulse_done();
      chk($sformatf("R4 req t%0d", t), irq_req, TAB[t].req);
      if (TAB[t].req) begin
        chk($sformatf("R4 vec t%0d", t), irq_vec, TAB[t].vec);
        pulse_ack();
        rest = TAB[t].evt & TAB[t].ena & ~(11'd1 << (TAB[t].vec / 2 - 1));
        chk($sformatf("R5 req drop t%0d", t), irq_req, 0);
        chk($sformatf("R5 gie drop t%0d", t), gie_o, 0);
        chk($sformatf("R5 sense rest t%0d", t), irq_sense, |rest);
      end else begin
        chk($sformatf("R2 sense masked t%0d", t), irq_sense, 0);
        chk($sformatf("R2 gie kept t%0d", t), gie_o, 1);
      end
    end

    // R1/R2: pending survives while masked, then shows when enabled
    do_reset();
    pulse_evt(11'h020);
    chk("R2 masked pending no sense", irq_sense, 0);
    wr(8'h20, 8'h20);
    chk("R1 pending held then enabled", irq_sense, 1);
    repeat (5) cyc();
    pulse_done();
    chk("R1 pending persists", irq_sense, 1);
    do_reset();
    chk("R10 reset clears pending", irq_sense, 0);
    rd(8'h20, d); chk("R10 reset clears enable", d, 0);

    // R8: enable readback, unmapped, status bits
    wr(8'h21, 8'hFF);
    rd(8'h21, d); chk("R8 0x21 upper bits zero", d, 8'h07);
    rd(8'h30, d); chk("R8 unmapped read", d, 0);

    // R9: sense while globally disabled; status bit7, bit2
    wr(8'h20, 8'h01);
    pulse_evt(11'h001);
    chk("R9 sense with gie off", irq_sense, 1);
    rd(8'hFF, d); chk("R9 status sense bit", d, 8'h80);
    pulse_done();
    chk("R3 no req with gie off", irq_req, 0);

    // R3: gie on but no instruction boundary
    pulse_ei();
    rd(8'hFF, d); chk("R8 status gie bit", d, 8'h84);
    repeat (3) cyc();
    chk("R3 no req without boundary", irq_req, 0);

    // R3: hold with frozen vector; higher source arrives meanwhile
    wr(8'h21, 8'h04);            // enable source 10 as well
    do_reset();
    set_ena(11'h7FF);
    pulse_evt(11'h010);          // source 4
    pulse_ei();
    pulse_done();
    chk("R3 req raised", irq_req, 1);
    chk("R4 vec src4", irq_vec, 10);
    pulse_evt(11'h001);          // higher priority, while held
    repeat (3) cyc();
    chk("R3 req held", irq_req, 1);
    chk("R3 vec frozen", irq_vec, 10);
    pulse_ack();
    pulse_ei();
    pulse_done();
    chk("R4 next winner src0", irq_vec, 2);
    pulse_ack();

    // R6: event collides with acknowledge of same source
    do_reset();
    wr(8'h20, 8'h08);
    pulse_evt(11'h008);
    pulse_ei();
    pulse_done();
    chk("R6 req src3", irq_vec, 8);
    src_evt = 11'h008; irq_ack = 1'b1; cyc(); src_evt = '0; irq_ack = 1'b0;
    chk("R6 req dropped", irq_req, 0);
    chk("R6 pending survives", irq_sense, 1);
    pulse_ei();
    pulse_done();
    chk("R6 re-requested", irq_req, 1);
    pulse_ack();

    // R5: ack without request is ignored
    do_reset();
    pulse_ei();
    pulse_ack();
    chk("R5 stray ack keeps gie", gie_o, 1);

    // R7: DI vs EI, RETI
    cpu_di = 1'b1; cpu_ei = 1'b1; cyc(); cpu_di = 1'b0; cpu_ei = 1'b0;
    chk("R7 di wins over ei", gie_o, 0);
    cpu_reti = 1'b1; cyc(); cpu_reti = 1'b0;
    chk("R7 reti sets gie", gie_o, 1);
    cpu_di = 1'b1; cyc(); cpu_di = 1'b0;
    chk("R7 di clears gie", gie_o, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule